// File: doc/BRIEF.md
# VBI Line Blanking Controller

This block follows the line number and field of an interlaced 525-line or 625-line raster. It uses this to decide, line by line, how the video path treats the samples on that line. A line in the vertical blanking interval (VBI) is either forced to blanking level or, when partial blanking is enabled, passed through so that data carried in the incoming stream reaches the output. Data of this kind includes widescreen signalling and copy-control words. Lines outside the VBI are active picture. For the 525-line format the block also gives a per-line pedestal enable, taken from a 32-bit mask over two 16-line windows.

Line advance comes from a one-cycle line-start pulse. Frame alignment comes from the field input. When the field input changes while the active-low horizontal sync input is low, a resynchronisation is armed. The next line-start then loads the first line of the field that the field input now indicates. An optional external blanking input can force blanking on any line. When that input is disabled, only the normally blanked lines are blanked.

Top module: `vbi_line_ctrl`

## Requirements
- R1: After reset, and before the first line-start, line_o is 0, field_o is 0, blank_o is 1, pass_vbi_o is 0.
- R2: Each line_start_i pulse with no armed resync advances line_o by one. After line 525 (fmt_625_i=0) or line 625 (fmt_625_i=1) it wraps to 1. Without a pulse, line_o holds.
- R3: field_o is 1 on lines 264..525 in the 525 format and on lines 314..625 in the 625 format. It is 0 on all other lines.
- R4: 525 format with partial_i=0: lines 1..21, 262..284 and 525 give blank_o=1 and pass_vbi_o=0. All other lines give blank_o=0 and pass_vbi_o=0.
- R5: 625 format with partial_i=0: lines 1..22, 311..335, 624 and 625 give blank_o=1. All other lines give blank_o=0. pass_vbi_o stays 0 on every line.
- R6: 525 format with partial_i=1: lines 10..21 and 274..284 give pass_vbi_o=1 and blank_o=0. The remaining VBI lines (1..9, 262..272, 525) stay blanked.
- R7: 525 format with partial_i=1, line 273: blank_o=1 for the first HALF_LINE cycles after the line-start edge. From then on, pass_vbi_o=1 and blank_o=0.
- R8: 625 format with partial_i=1: lines 7..22 and 319..335 give pass_vbi_o=1 and blank_o=0. Lines 1..6, 311..318, 624 and 625 stay blanked.
- R9: blank_o and pass_vbi_o are never 1 together. pass_vbi_o is 1 only while partial_i is 1.
- R10: 525 format: on lines 10..25, ped_o equals ped_mask_i bit (line-10). On lines 273..288, ped_o equals bit (line-257). On every other line, ped_o is 1.
- R11: 625 format: ped_o is 0 on every line.
- R12: A change of field_i while hsync_ni=0 arms a resync. The next line_start_i loads line 1 with field 0 if field_i=0, or the first field-2 line with field 1 if field_i=1. The first field-2 line is 264 in the 525 format and 314 in the 625 format. A change of field_i while hsync_ni=1 has no effect on the count.
- R13: While ext_blank_en_i=1 and ext_blank_ni=0, blank_o=1 and pass_vbi_o=0 on any line. While ext_blank_en_i=0, ext_blank_ni has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | One-cycle pulse at the start of each line |
| hsync_ni | input | 1 | Horizontal sync, active low |
| field_i | input | 1 | Field indicator, 0 = first field |
| fmt_625_i | input | 1 | 0 = 525-line format, 1 = 625-line format |
| partial_i | input | 1 | 1 = pass data on opened VBI lines |
| ext_blank_en_i | input | 1 | Enables the external blanking input |
| ext_blank_ni | input | 1 | External blanking request, active low |
| ped_mask_i | input | 32 | Pedestal mask: bits 0..15 cover lines 10..25, bits 16..31 cover lines 273..288 |
| blank_o | output | 1 | Force blanking level on the current sample |
| pass_vbi_o | output | 1 | Pass incoming data on the current VBI sample |
| ped_o | output | 1 | Apply the setup pedestal |
| line_o | output | 10 | Current line number, 0 until the first line-start |
| field_o | output | 1 | Current field flag |

## Verification
The bench targets the window edges on both sides: lines 9/10, 21/22, 261/262, 272/274, 284/285, 524/525 for 525 lines, and 6/7, 22/23, 310/311, 318/319, 335/336, 623/624 for 625 lines. An off-by-one range would open or blank a whole wrong line there. Line 273 is sampled just before and just at the half-line count. A design that treats it as a whole-line case would pass the first half or blank the second. Pedestal mask bits are checked at both ends of each window with an alternating pattern, which exposes a shifted or reversed index. Resync is driven with sync both low and high, which catches a design that reframes on any field change. Both format wraps are exercised, which catches a counter that wraps at the wrong total.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
  localparam int unsigned LINE_W   = 10;
  localparam int unsigned PED_SPAN = 16;
  localparam int unsigned PED_W    = 2 * PED_SPAN;

  typedef enum logic {FMT_525 = 1'b0, FMT_625 = 1'b1} fmt_e;

  function automatic logic [LINE_W-1:0] total_lines(fmt_e f);
    return (f == FMT_625) ? 10'd625 : 10'd525;
  endfunction

  function automatic logic [LINE_W-1:0] field2_line(fmt_e f);
    return (f == FMT_625) ? 10'd314 : 10'd264;
  endfunction

  function automatic logic in_rng(logic [LINE_W-1:0] l, logic [LINE_W-1:0] lo,
                                  logic [LINE_W-1:0] hi);
    return (l >= lo) && (l <= hi);
  endfunction
endpackage

// File: rtl/vbi_frame_sync.sv
module vbi_frame_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_start_i,
  input  logic hsync_ni,
  input  logic field_i,
  output logic resync_o
);
  logic valid_q, field_q, arm_q;
  logic edge_w;

  assign edge_w   = valid_q && (field_i != field_q) && !hsync_ni;
  assign resync_o = arm_q || edge_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      field_q <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      valid_q <= 1'b1;
      field_q <= field_i;
      if (line_start_i)  arm_q <= 1'b0;
      else if (edge_w)   arm_q <= 1'b1;
    end
  end
endmodule

// File: rtl/vbi_line_counter.sv
module vbi_line_counter
  import vbi_pkg::*;
#(
  parameter int unsigned HALF_LINE = 858
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  fmt_e              fmt_i,
  input  logic              resync_i,
  input  logic              field_i,
  output logic [LINE_W-1:0] line_o,
  output logic              field_o,
  output logic              half_o
);
  localparam int unsigned CW = $clog2(HALF_LINE + 1);

  logic [LINE_W-1:0] line_q, line_d;
  logic              field_q;
  logic [CW-1:0]     cnt_q;

  always_comb begin
    if (resync_i)                          line_d = field_i ? field2_line(fmt_i) : 10'd1;
    else if (line_q >= total_lines(fmt_i)) line_d = 10'd1;
    else                                   line_d = line_q + 10'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      field_q <= 1'b0;
      cnt_q   <= '0;
    end else if (line_start_i) begin
      line_q  <= line_d;
      field_q <= (line_d >= field2_line(fmt_i));
      cnt_q   <= '0;
    end else if (cnt_q != CW'(HALF_LINE)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign line_o  = line_q;
  assign field_o = field_q;
  assign half_o  = (cnt_q == CW'(HALF_LINE));
endmodule

// File: rtl/vbi_window_decode.sv
module vbi_window_decode
  import vbi_pkg::*;
(
  input  logic [LINE_W-1:0] line_i,
  input  fmt_e              fmt_i,
  input  logic              half_i,
  input  logic              partial_i,
  input  logic              ext_en_i,
  input  logic              ext_ni,
  input  logic [PED_W-1:0]  mask_i,
  output logic              blank_o,
  output logic              pass_o,
  output logic              ped_o
);
  logic vbi, opened, ext_blk;
  logic [LINE_W-1:0] off_a, off_b;

  always_comb begin
    if (fmt_i == FMT_625) begin
      vbi    = (line_i >= 10'd624) || (line_i <= 10'd22) || in_rng(line_i, 10'd311, 10'd335);
      opened = in_rng(line_i, 10'd7, 10'd22) || in_rng(line_i, 10'd319, 10'd335);
    end else begin
      vbi    = (line_i >= 10'd525) || (line_i <= 10'd21) || in_rng(line_i, 10'd262, 10'd284);
      // line 273 opens only from its second half
      opened = in_rng(line_i, 10'd10, 10'd21) || in_rng(line_i, 10'd274, 10'd284) ||
               ((line_i == 10'd273) && half_i);
    end
  end

  assign ext_blk = ext_en_i && !ext_ni;
  assign pass_o  = vbi && opened && partial_i && !ext_blk;
  assign blank_o = ext_blk || (vbi && !pass_o);

  assign off_a = line_i - 10'd10;
  assign off_b = line_i - 10'd273;

  always_comb begin
    if (fmt_i == FMT_625)                    ped_o = 1'b0;
    else if (in_rng(line_i, 10'd10, 10'd25))   ped_o = mask_i[{1'b0, off_a[3:0]}];
    else if (in_rng(line_i, 10'd273, 10'd288)) ped_o = mask_i[{1'b1, off_b[3:0]}];
    else                                     ped_o = 1'b1;
  end
endmodule

// File: rtl/vbi_line_ctrl.sv
module vbi_line_ctrl
  import vbi_pkg::*;
#(
  parameter int unsigned HALF_LINE = 858
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic              hsync_ni,
  input  logic              field_i,
  input  logic              fmt_625_i,
  input  logic              partial_i,
  input  logic              ext_blank_en_i,
  input  logic              ext_blank_ni,
  input  logic [PED_W-1:0]  ped_mask_i,
  output logic              blank_o,
  output logic              pass_vbi_o,
  output logic              ped_o,
  output logic [LINE_W-1:0] line_o,
  output logic              field_o
);
  fmt_e fmt_w;
  logic resync_w, half_w;

  assign fmt_w = fmt_e'(fmt_625_i);

  vbi_frame_sync u_sync (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_start_i (line_start_i),
    .hsync_ni     (hsync_ni),
    .field_i      (field_i),
    .resync_o     (resync_w)
  );

  vbi_line_counter #(.HALF_LINE(HALF_LINE)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_start_i (line_start_i),
    .fmt_i        (fmt_w),
    .resync_i     (resync_w),
    .field_i      (field_i),
    .line_o       (line_o),
    .field_o      (field_o),
    .half_o       (half_w)
  );

  vbi_window_decode u_dec (
    .line_i    (line_o),
    .fmt_i     (fmt_w),
    .half_i    (half_w),
    .partial_i (partial_i),
    .ext_en_i  (ext_blank_en_i),
    .ext_ni    (ext_blank_ni),
    .mask_i    (ped_mask_i),
    .blank_o   (blank_o),
    .pass_o    (pass_vbi_o),
    .ped_o     (ped_o)
  );
endmodule

// File: rtl/vbi_line_ctrl_chk.sv
module vbi_line_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       line_start_i,
  input logic       resync_i,
  input logic       fmt_625_i,
  input logic       partial_i,
  input logic       ext_blank_en_i,
  input logic       ext_blank_ni,
  input logic       blank_o,
  input logic       pass_vbi_o,
  input logic       ped_o,
  input logic [9:0] line_o,
  input logic       field_o
);
  // R9
  blank_pass_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(blank_o && pass_vbi_o));

  // R9
  pass_needs_partial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_vbi_o |-> partial_i);

  // R2
  line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> $stable(line_o));

  // R2
  wrap_525_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && !resync_i && !fmt_625_i && line_o == 10'd525) |=> line_o == 10'd1);

  // R3
  first_line_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o == 10'd1) |-> !field_o);

  // R11
  ped_625_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_625_i |-> !ped_o);

  // R13
  ext_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_blank_en_i && !ext_blank_ni) |-> (blank_o && !pass_vbi_o));
endmodule

bind vbi_line_ctrl vbi_line_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .line_start_i   (line_start_i),
  .resync_i       (resync_w),
  .fmt_625_i      (fmt_625_i),
  .partial_i      (partial_i),
  .ext_blank_en_i (ext_blank_en_i),
  .ext_blank_ni   (ext_blank_ni),
  .blank_o        (blank_o),
  .pass_vbi_o     (pass_vbi_o),
  .ped_o          (ped_o),
  .line_o         (line_o),
  .field_o        (field_o)
);

// File: tb/tb_vbi_line_ctrl.sv
module tb_vbi_line_ctrl;
  localparam int HALF = 4;
  localparam int NV   = 41;

  // {fmt_625, partial, line[9:0], exp_blank, exp_pass}
  localparam logic [13:0] VEC [NV] = '{
    {1'b0,1'b0,10'd1,2'b10},   {1'b0,1'b0,10'd9,2'b10},   {1'b0,1'b0,10'd10,2'b10},
    {1'b0,1'b0,10'd21,2'b10},  {1'b0,1'b0,10'd22,2'b00},  {1'b0,1'b0,10'd261,2'b00},
    {1'b0,1'b0,10'd262,2'b10}, {1'b0,1'b0,10'd273,2'b10}, {1'b0,1'b0,10'd284,2'b10},
    {1'b0,1'b0,10'd285,2'b00}, {1'b0,1'b0,10'd524,2'b00}, {1'b0,1'b0,10'd525,2'b10},
    {1'b0,1'b1,10'd9,2'b10},   {1'b0,1'b1,10'd10,2'b01},  {1'b0,1'b1,10'd21,2'b01},
    {1'b0,1'b1,10'd22,2'b00},  {1'b0,1'b1,10'd262,2'b10}, {1'b0,1'b1,10'd272,2'b10},
    {1'b0,1'b1,10'd274,2'b01}, {1'b0,1'b1,10'd284,2'b01}, {1'b0,1'b1,10'd285,2'b00},
    {1'b0,1'b1,10'd525,2'b10},
    {1'b1,1'b0,10'd6,2'b10},   {1'b1,1'b0,10'd22,2'b10},  {1'b1,1'b0,10'd23,2'b00},
    {1'b1,1'b0,10'd310,2'b00}, {1'b1,1'b0,10'd311,2'b10}, {1'b1,1'b0,10'd335,2'b10},
    {1'b1,1'b0,10'd336,2'b00}, {1'b1,1'b0,10'd623,2'b00}, {1'b1,1'b0,10'd624,2'b10},
    {1'b1,1'b0,10'd625,2'b10},
    {1'b1,1'b1,10'd6,2'b10},   {1'b1,1'b1,10'd7,2'b01},   {1'b1,1'b1,10'd22,2'b01},
    {1'b1,1'b1,10'd23,2'b00},  {1'b1,1'b1,10'd318,2'b10}, {1'b1,1'b1,10'd319,2'b01},
    {1'b1,1'b1,10'd335,2'b01}, {1'b1,1'b1,10'd336,2'b00}, {1'b1,1'b1,10'd624,2'b10}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        line_start_i = 1'b0;
  logic        hsync_ni = 1'b1;
  logic        field_i = 1'b0;
  logic        fmt_625_i = 1'b0;
  logic        partial_i = 1'b0;
  logic        ext_blank_en_i = 1'b0;
  logic        ext_blank_ni = 1'b1;
  logic [31:0] ped_mask_i = '0;
  logic        blank_o, pass_vbi_o, ped_o, field_o;
  logic [9:0]  line_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cur     = 0;
  logic       v_fmt, v_part, v_blank, v_pass;
  logic [9:0] v_line;

  always #2 clk_i = ~clk_i;

  vbi_line_ctrl #(.HALF_LINE(HALF)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_start_i(line_start_i), .hsync_ni(hsync_ni),
    .field_i(field_i), .fmt_625_i(fmt_625_i), .partial_i(partial_i),
    .ext_blank_en_i(ext_blank_en_i), .ext_blank_ni(ext_blank_ni), .ped_mask_i(ped_mask_i),
    .blank_o(blank_o), .pass_vbi_o(pass_vbi_o), .ped_o(ped_o), .line_o(line_o),
    .field_o(field_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_raw();
    @(negedge clk_i) line_start_i = 1'b1;
    @(negedge clk_i) line_start_i = 1'b0;
  endtask

  task automatic pulse();
    int tot;
    tot = fmt_625_i ? 625 : 525;
    pulse_raw();
    cur = (cur >= tot) ? 1 : cur + 1;
  endtask

  task automatic resync_to(input logic f);
    @(negedge clk_i) begin hsync_ni = 1'b1; field_i = ~f; end
    @(negedge clk_i) begin hsync_ni = 1'b0; field_i = f; end
    @(negedge clk_i) hsync_ni = 1'b1;
    pulse_raw();
    cur = f ? (fmt_625_i ? 314 : 264) : 1;
  endtask

  task automatic go_line(input int l);
    while (cur != l) pulse();
  endtask

  function automatic int exp_field(input logic f625, input int l);
    return f625 ? int'(l >= 314) : int'(l >= 264);
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 line_o", int'(line_o), 0);
    chk("R1 field_o", int'(field_o), 0);
    chk("R1 blank_o", int'(blank_o), 1);
    chk("R1 pass_vbi_o", int'(pass_vbi_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 line_o after release", int'(line_o), 0);

    // table walk: R2 R3 R4 R5 R6 R8 R9
    for (int i = 0; i < NV; i++) begin
      {v_fmt, v_part, v_line, v_blank, v_pass} = VEC[i];
      if (v_fmt != fmt_625_i || v_part != partial_i || int'(v_line) < cur) begin
        fmt_625_i = v_fmt;
        partial_i = v_part;
        resync_to(1'b0);
      end
      go_line(int'(v_line));
      chk($sformatf("R2 line %0d", v_line), int'(line_o), int'(v_line));
      chk($sformatf("R3 field line %0d", v_line), int'(field_o), exp_field(v_fmt, int'(v_line)));
      chk($sformatf("%s blank line %0d", v_fmt ? (v_part ? "R8" : "R5") : (v_part ? "R6" : "R4"),
                    v_line), int'(blank_o), int'(v_blank));
      chk($sformatf("R9 pass line %0d fmt %0d part %0d", v_line, v_fmt, v_part),
          int'(pass_vbi_o), int'(v_pass));
    end

    // R2 625 wrap
    go_line(625);
    pulse();
    chk("R2 wrap 625", int'(line_o), 1);
    chk("R3 field after 625 wrap", int'(field_o), 0);

    // R2 525 wrap and hold
    fmt_625_i = 1'b0;
    partial_i = 1'b0;
    resync_to(1'b1);
    chk("R12 load field2 525", int'(line_o), 264);
    chk("R3 field at 264", int'(field_o), 1);
    go_line(525);
    pulse();
    chk("R2 wrap 525", int'(line_o), 1);
    repeat (5) @(negedge clk_i);
    chk("R2 hold without pulse", int'(line_o), 1);

    // R7 half-line opening on 273
    partial_i = 1'b1;
    go_line(273);
    chk("R7 273 start blank", int'(blank_o), 1);
    chk("R7 273 start pass", int'(pass_vbi_o), 0);
    repeat (HALF - 1) @(negedge clk_i);
    chk("R7 273 before half pass", int'(pass_vbi_o), 0);
    @(negedge clk_i);
    chk("R7 273 at half pass", int'(pass_vbi_o), 1);
    chk("R7 273 at half blank", int'(blank_o), 0);

    // R10 pedestal mask, 525
    ped_mask_i = 32'h0001_8005;
    resync_to(1'b0);
    for (int l = 9; l <= 26; l++) begin
      go_line(l);
      chk($sformatf("R10 ped line %0d", l), int'(ped_o),
          (l >= 10 && l <= 25) ? int'(ped_mask_i[l-10]) : 1);
    end
    for (int l = 272; l <= 289; l++) begin
      go_line(l);
      chk($sformatf("R10 ped line %0d", l), int'(ped_o),
          (l >= 273 && l <= 288) ? int'(ped_mask_i[l-257]) : 1);
    end

    // R11 no pedestal in 625
    fmt_625_i = 1'b1;
    ped_mask_i = '1;
    resync_to(1'b0);
    for (int l = 8; l <= 12; l++) begin
      go_line(l);
      chk($sformatf("R11 ped line %0d", l), int'(ped_o), 0);
    end
    go_line(100);
    chk("R11 ped active line", int'(ped_o), 0);

    // R12 field change with sync high is ignored
    fmt_625_i = 1'b0;
    resync_to(1'b0);
    go_line(50);
    @(negedge clk_i) begin hsync_ni = 1'b1; field_i = 1'b1; end
    pulse();
    chk("R12 ignored change", int'(line_o), 51);
    @(negedge clk_i) begin hsync_ni = 1'b0; field_i = 1'b0; end
    @(negedge clk_i) hsync_ni = 1'b1;
    pulse_raw();
    cur = 1;
    chk("R12 frame start load", int'(line_o), 1);
    chk("R12 frame start field", int'(field_o), 0);

    // R13 external blanking
    partial_i = 1'b1;
    go_line(100);
    @(negedge clk_i) begin ext_blank_en_i = 1'b0; ext_blank_ni = 1'b0; end
    #1 chk("R13 disabled ext blank", int'(blank_o), 0);
    @(negedge clk_i) ext_blank_en_i = 1'b1;
    #1 chk("R13 enabled ext blank", int'(blank_o), 1);
    @(negedge clk_i) ext_blank_ni = 1'b1;
    #1 chk("R13 ext blank released", int'(blank_o), 0);
    resync_to(1'b0);
    go_line(15);
    @(negedge clk_i) ext_blank_ni = 1'b0;
    #1 chk("R13 opened line pass", int'(pass_vbi_o), 0);
    chk("R13 opened line blank", int'(blank_o), 1);
    @(negedge clk_i) begin ext_blank_en_i = 1'b0; end
    #1 chk("R13 disabled opened pass", int'(pass_vbi_o), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule